// File: doc/BRIEF.md
# PLL Mode Strap Latch and Override

This block decides which operating mode a clock buffer's PLL runs in: low bandwidth, bypass, or high bandwidth. A three-level board strap selects the default. The strap arrives already decoded into a 2-bit level. The block captures it while cold reset is held and shows the captured code in the top two bits of a single configuration byte. These two bits are read-only.

Software can replace the strapped mode. It writes an enable bit and a 2-bit mode code into the same byte. The replacement reaches the PLL only at the next warm reset. Between resets the mode seen by the PLL never moves. A cold reset clears the enable and the code, so after power-up the strap always decides.

The outputs are the effective 2-bit mode code and a bypass flag. When the bypass flag is high, the input clock goes straight to the output stage and skips the PLL. The host side is a plain byte write strobe plus a read byte that is always valid. There is no data stream, so no valid/ready handshake exists, and every pin is a plain control or status level.

Top module: `pll_mode_strap_ctl`

## Requirements
- R1: The strap level is captured at every clock edge where `cold_rst_n` is low and is shown on `rd_data[7:6]`. The level-to-code mapping is: level 2'b00 (low) gives 2'b00 (low bandwidth), level 2'b01 (mid) gives 2'b01 (bypass), and levels 2'b10 (high) and 2'b11 (invalid) both give 2'b11 (high bandwidth).
- R2: Once cold reset is released, `rd_data[7:6]` keeps its value. Writes, warm resets and later strap changes do not alter it.
- R3: When `wr_en` is high at a clock edge where both resets are high, `wr_data[3]` is stored as the override enable and `wr_data[2:1]` is stored as the override code. These fields read back on `rd_data[3]` and `rd_data[2:1]`. `rd_data[5:4]` and `rd_data[0]` always read 0. Writes made while either reset is low are ignored.
- R4: At clock edges where neither reset is low, `pll_mode` and `pll_bypass` do not change, whatever is written.
- R5: A warm reset with the enable set loads `pll_mode` from the override code. Code 2'b10 is loaded as 2'b11.
- R6: A warm reset with the enable clear loads `pll_mode` from the latched strap code.
- R7: `pll_bypass` is 1 exactly when `pll_mode` is 2'b01.
- R8: A cold reset clears the enable and override fields to 0 and sets `pll_mode` to the strap code.
- R9: When both resets are low together, the cold reset action applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| cold_rst_n | input | 1 | Power-up reset, active low, synchronous |
| warm_rst_n | input | 1 | System warm reset, active low, synchronous |
| strap_lvl | input | 2 | Pre-decoded strap level: 00 low, 01 mid, 10 high |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte written to the configuration register |
| rd_data | output | 8 | Configuration byte read value |
| pll_mode | output | 2 | Effective PLL mode code |
| pll_bypass | output | 1 | Route input clock directly to the output stage |

## Verification
The assertions assume the strap level holds steady during the last clock of cold reset. They also assume that warm reset is applied only after cold reset has been released at least once. The assertions about what a warm reset loads rely on the override fields staying frozen while warm reset is low; the design guarantees this by ignoring writes during reset. The bench changes `strap_lvl`, `wr_en` and the resets only on falling clock edges. It holds each reset for two cycles and releases cold reset before any warm reset. It also issues writes during a warm reset and moves the strap after latching, to show that both are ignored.

// File: rtl/pms_pkg.sv
package pms_pkg;
  localparam int CFG_W   = 8;
  localparam int MODE_W  = 2;
  localparam int RB_LO   = 6;
  localparam int RB_HI   = RB_LO + MODE_W - 1;
  localparam int EN_BIT  = 3;
  localparam int OV_LO   = 1;
  localparam int OV_HI   = OV_LO + MODE_W - 1;

  typedef enum logic [MODE_W-1:0] {
    MODE_LBW = 2'b00,
    MODE_BYP = 2'b01,
    MODE_RSV = 2'b10,
    MODE_HBW = 2'b11
  } pll_mode_e;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_BAD  = 2'b11
  } strap_lvl_e;

  // Three-level strap to mode code; an invalid level falls to high bandwidth.
  function automatic logic [MODE_W-1:0] lvl_to_code(input logic [1:0] lvl);
    logic [MODE_W-1:0] c;
    case (lvl)
      LVL_LOW:  c = MODE_LBW;
      LVL_MID:  c = MODE_BYP;
      default:  c = MODE_HBW;
    endcase
    return c;
  endfunction

  // Fold the unused code into high bandwidth.
  function automatic logic [MODE_W-1:0] canon(input logic [MODE_W-1:0] c);
    return (c == MODE_RSV) ? MODE_HBW : c;
  endfunction
endpackage

// File: rtl/pms_strap_latch.sv
module pms_strap_latch
  import pms_pkg::*;
(
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic [1:0]        strap_lvl,
  output logic [MODE_W-1:0] strap_code
);
  logic [MODE_W-1:0] code_q;

  // Track the strap while cold reset is held; freeze on release.
  always_ff @(posedge clk) begin
    if (!cold_rst_n) code_q <= lvl_to_code(strap_lvl);
  end

  assign strap_code = code_q;
endmodule

// File: rtl/pms_cfg_reg.sv
module pms_cfg_reg
  import pms_pkg::*;
(
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              warm_rst_n,
  input  logic              wr_en,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic [MODE_W-1:0] strap_code,
  output logic              ovr_en,
  output logic [MODE_W-1:0] ovr_code,
  output logic [CFG_W-1:0]  rd_data
);
  logic              en_q;
  logic [MODE_W-1:0] code_q;
  logic              wr_ok;

  assign wr_ok = wr_en && cold_rst_n && warm_rst_n;

  always_ff @(posedge clk) begin
    if (!cold_rst_n) begin
      en_q   <= 1'b0;
      code_q <= '0;
    end else if (wr_ok) begin
      en_q   <= wr_data[EN_BIT];
      code_q <= wr_data[OV_HI:OV_LO];
    end
  end

  always_comb begin
    rd_data              = '0;
    rd_data[RB_HI:RB_LO] = strap_code;
    rd_data[EN_BIT]      = en_q;
    rd_data[OV_HI:OV_LO] = code_q;
  end

  assign ovr_en   = en_q;
  assign ovr_code = code_q;
endmodule

// File: rtl/pms_mode_sel.sv
module pms_mode_sel
  import pms_pkg::*;
(
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              warm_rst_n,
  input  logic [1:0]        strap_lvl,
  input  logic [MODE_W-1:0] strap_code,
  input  logic              ovr_en,
  input  logic [MODE_W-1:0] ovr_code,
  output logic [MODE_W-1:0] mode,
  output logic              bypass
);
  logic [MODE_W-1:0] mode_q, mode_nx;
  logic              byp_q;
  logic              load;

  always_comb begin
    load    = 1'b1;
    mode_nx = mode_q;
    if (!cold_rst_n)
      mode_nx = lvl_to_code(strap_lvl);
    else if (!warm_rst_n)
      mode_nx = ovr_en ? canon(ovr_code) : strap_code;
    else
      load = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      mode_q <= mode_nx;
      byp_q  <= (mode_nx == MODE_BYP);
    end
  end

  assign mode   = mode_q;
  assign bypass = byp_q;
endmodule

// File: rtl/pll_mode_strap_ctl.sv
module pll_mode_strap_ctl
  import pms_pkg::*;
(
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              warm_rst_n,
  input  logic [1:0]        strap_lvl,
  input  logic              wr_en,
  input  logic [CFG_W-1:0]  wr_data,
  output logic [CFG_W-1:0]  rd_data,
  output logic [MODE_W-1:0] pll_mode,
  output logic              pll_bypass
);
  logic [MODE_W-1:0] strap_code;
  logic              ovr_en;
  logic [MODE_W-1:0] ovr_code;

  pms_strap_latch u_latch (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .strap_lvl  (strap_lvl),
    .strap_code (strap_code)
  );

  pms_cfg_reg u_cfg (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .warm_rst_n (warm_rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .strap_code (strap_code),
    .ovr_en     (ovr_en),
    .ovr_code   (ovr_code),
    .rd_data    (rd_data)
  );

  pms_mode_sel u_sel (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .warm_rst_n (warm_rst_n),
    .strap_lvl  (strap_lvl),
    .strap_code (strap_code),
    .ovr_en     (ovr_en),
    .ovr_code   (ovr_code),
    .mode       (pll_mode),
    .bypass     (pll_bypass)
  );
endmodule

// File: rtl/pms_checker.sv
module pms_checker
  import pms_pkg::*;
(
  input logic              clk,
  input logic              cold_rst_n,
  input logic              warm_rst_n,
  input logic [CFG_W-1:0]  rd_data,
  input logic [MODE_W-1:0] pll_mode,
  input logic              pll_bypass
);
  a_r2_readback_frozen: assert property (@(posedge clk) disable iff (!cold_rst_n)
    1'b1 |=> $stable(rd_data[RB_HI:RB_LO]));

  a_r4_mode_held: assert property (@(posedge clk) disable iff (!cold_rst_n)
    warm_rst_n |=> ($stable(pll_mode) && $stable(pll_bypass)));

  a_r5_warm_override: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (!warm_rst_n && rd_data[EN_BIT]) |=>
      (pll_mode == (($past(rd_data[OV_HI:OV_LO]) == 2'b10) ? 2'b11
                                                        : $past(rd_data[OV_HI:OV_LO]))));

  a_r6_warm_strap: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (!warm_rst_n && !rd_data[EN_BIT]) |=> (pll_mode == $past(rd_data[RB_HI:RB_LO])));

  a_r7_bypass_match: assert property (@(posedge clk) disable iff (!cold_rst_n)
    1'b1 |=> (pll_bypass == (pll_mode == 2'b01)));
endmodule

bind pll_mode_strap_ctl pms_checker u_chk (
  .clk        (clk),
  .cold_rst_n (cold_rst_n),
  .warm_rst_n (warm_rst_n),
  .rd_data    (rd_data),
  .pll_mode   (pll_mode),
  .pll_bypass (pll_bypass)
);

// File: tb/sim_pll_mode_strap_ctl.sv
module sim_pll_mode_strap_ctl;
  logic       clk = 1'b0;
  logic       cold_rst_n = 1'b0;
  logic       warm_rst_n = 1'b1;
  logic [1:0] strap_lvl = 2'b00;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [1:0] pll_mode;
  logic       pll_bypass;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pll_mode_strap_ctl u0 (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .strap_lvl(strap_lvl), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pll_mode(pll_mode), .pll_bypass(pll_bypass)
  );

  // {strap level, written byte, expected readback code, expected mode after warm reset}
  localparam int NV = 9;
  localparam logic [13:0] VEC [NV] = '{
    {2'b00, 8'h00, 2'b00, 2'b00},
    {2'b01, 8'h00, 2'b01, 2'b01},
    {2'b10, 8'h00, 2'b11, 2'b11},
    {2'b11, 8'h00, 2'b11, 2'b11},
    {2'b00, 8'h0A, 2'b00, 2'b01},
    {2'b10, 8'h08, 2'b11, 2'b00},
    {2'b01, 8'h0C, 2'b01, 2'b11},
    {2'b00, 8'h06, 2'b00, 2'b00},
    {2'b01, 8'hFE, 2'b01, 2'b11}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cold_reset(input logic [1:0] lvl);
    @(negedge clk); cold_rst_n = 1'b0; strap_lvl = lvl;
    @(negedge clk); @(negedge clk); cold_rst_n = 1'b1;
  endtask

  task automatic warm_reset();
    @(negedge clk); warm_rst_n = 1'b0;
    @(negedge clk); @(negedge clk); warm_rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < 20000; k++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_rd;
    logic [1:0] m0;
    // Reset state (R8, R1)
    cold_reset(2'b01);
    @(negedge clk);
    chk("R8 reset rd", rd_data, 8'h40);
    chk("R8 reset mode", {6'd0, pll_mode}, 8'h01);
    chk("R7 reset bypass", {7'd0, pll_bypass}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] lvl; logic [7:0] wd; logic [1:0] rb; logic [1:0] em;
      {lvl, wd, rb, em} = VEC[i];
      cold_reset(lvl);
      @(negedge clk);
      chk("R1 readback", {6'd0, rd_data[7:6]}, {6'd0, rb});
      chk("R8 mode after cold", {6'd0, pll_mode}, {6'd0, rb});
      m0 = pll_mode;
      wr(wd);
      exp_rd = {rb, 2'b00, wd[3:1], 1'b0};
      chk("R3 rd after write", rd_data, exp_rd);
      chk("R4 mode held after write", {6'd0, pll_mode}, {6'd0, m0});
      warm_reset();
      @(negedge clk);
      chk(wd[3] ? "R5 warm override" : "R6 warm strap", {6'd0, pll_mode}, {6'd0, em});
      chk("R7 bypass", {7'd0, pll_bypass}, {7'd0, em == 2'b01});
      chk("R2 readback after warm", {6'd0, rd_data[7:6]}, {6'd0, rb});
    end

    // R2: strap moves after latch, and during a warm reset
    cold_reset(2'b00);
    @(negedge clk); strap_lvl = 2'b10;
    @(negedge clk);
    chk("R2 strap moved", {6'd0, rd_data[7:6]}, 8'h00);
    warm_reset();
    @(negedge clk);
    chk("R2 strap moved warm", {6'd0, rd_data[7:6]}, 8'h00);
    chk("R6 warm keeps latched strap", {6'd0, pll_mode}, 8'h00);

    // R3: write during warm reset ignored
    @(negedge clk); warm_rst_n = 1'b0; wr_en = 1'b1; wr_data = 8'h0E;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk); warm_rst_n = 1'b1;
    @(negedge clk);
    chk("R3 write in warm ignored", rd_data, 8'h00);
    chk("R3 mode after ignored write", {6'd0, pll_mode}, 8'h00);

    // R5: reserved code folds to high bandwidth; then reprogram twice
    wr(8'h0C);
    warm_reset(); @(negedge clk);
    chk("R5 code 10 to 11", {6'd0, pll_mode}, 8'h03);
    wr(8'h0A);
    @(negedge clk);
    chk("R4 no change before warm", {6'd0, pll_mode}, 8'h03);
    warm_reset(); @(negedge clk);
    chk("R5 second override", {6'd0, pll_mode}, 8'h01);
    chk("R7 bypass on override", {7'd0, pll_bypass}, 8'h01);

    // R8: cold reset clears override
    cold_reset(2'b00);
    @(negedge clk);
    chk("R8 override cleared", rd_data, 8'h00);
    warm_reset(); @(negedge clk);
    chk("R8 strap governs", {6'd0, pll_mode}, 8'h00);

    // R9: both resets low together, cold wins
    wr(8'h0E);
    @(negedge clk); cold_rst_n = 1'b0; warm_rst_n = 1'b0; strap_lvl = 2'b01;
    @(negedge clk); @(negedge clk); cold_rst_n = 1'b1; warm_rst_n = 1'b1;
    @(negedge clk);
    chk("R9 cold priority mode", {6'd0, pll_mode}, 8'h01);
    chk("R9 cold priority rd", rd_data, 8'h40);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule